// File: doc/BRIEF.md
# Cascadable Line-Scan Readout Sequencer

This block holds the scan-control logic of one image-sensor die that is chained end to end with identical dies on a line-scan module. A module-wide start pulse reaches every die at once and opens a pre-scan window of 75 dummy clocks. A die strapped as the lead of the chain then reads out its active pixels on its own. A die strapped as a follower waits for a pulse on its chain start input, which is wired to the hand-off output of the die before it. One pixel advances per pixel clock. The pixel count is set by a 2-bit resolution select.

The hand-off pulse leaves each die nine pixels before that die's last active pixel. The next die samples the pulse one clock later. It then spends a short lead-in so that its pixel 1 lands on the clock right after the previous die's last pixel, and the chained video stream has no gap. All start inputs are sampled on the falling clock edge, and all state moves on that edge. The output-amplifier enable is raised only while this die is putting pixels out.

Top module: `line_scan_seq`

## Requirements
- R1: While `rst_n` is low at a falling clock edge, all state clears; after reset `pix_valid_o`, `handoff_o` and `amp_pwr_o` are 0 and `pix_num_o` is 0.
- R2: On a lead die (`lead_strap_i`=1), counting the falling edge that samples a rising `glob_start_i` as clock 1, `pix_valid_o` rises on clock 76 with `pix_num_o`=1, and `pix_num_o` then rises by one on every clock.
- R3: The active pixel count is 1376 for `res_sel_i`=00, 688 for 01, 344 for 10 and 172 for 11; `pix_valid_o` drops on the clock after pixel number equals that count, and `pix_num_o` returns to 0.
- R4: `handoff_o` is high for exactly one clock, on the clock that shows pixel 1367, 679, 335 or 163 for the four resolution codes; at 00 this is clock 1442 after the global start, and the last pixel falls on clock 1451.
- R5: A follower die (`lead_strap_i`=0) runs the 75-clock pre-scan after a global start but never starts its readout on its own.
- R6: On a follower, counting the falling edge that samples a rising `chain_start_i` as clock 1, pixel 1 appears on clock 10.
- R7: A start input held high across many falling edges is taken as one start only; no further scan begins until the input goes low and rises again.
- R8: Rising edges on either start input that arrive during a pre-scan, a lead-in or an active readout are ignored; the readout in progress continues unchanged.
- R9: `amp_pwr_o` is high on exactly those clocks where `pix_valid_o` is high.
- R10: A lead die ignores `chain_start_i`.
- R11: The resolution code is captured when a scan starts; changing `res_sel_i` during the scan does not alter its pixel count or hand-off position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock; all state moves on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| glob_start_i | input | 1 | Module-wide start pulse, shared by every die |
| chain_start_i | input | 1 | Start from the preceding die's hand-off output |
| lead_strap_i | input | 1 | 1 = first die of the chain, 0 = follower |
| res_sel_i | input | 2 | Resolution code: 00 full, 01 half, 10 quarter, 11 eighth |
| pix_valid_o | output | 1 | An active pixel is being read out this clock |
| pix_num_o | output | 11 | 1-based number of the active pixel, 0 when none |
| handoff_o | output | 1 | One-clock end-of-scan pulse for the next die |
| amp_pwr_o | output | 1 | Output-amplifier power enable |

## Verification
The assertions assume that reset is held across at least one falling edge before any start, and that the strap is fixed while a scan is running, as a wired strap is. They also assume that a start input changes only between falling edges. The bench holds the strap constant through each scenario and pulses reset before every case. It changes all inputs just after the rising clock edge, so each input is stable half a period before the falling edge that samples it.

// File: rtl/line_scan_pkg.sv
// Shared types for the line-scan readout sequencer.
package line_scan_pkg;
    // Phases of one die's scan.
    typedef enum logic [2:0] {
        ST_IDLE,    // nothing to do
        ST_PRE,     // dummy clocks after a global start
        ST_WAIT,    // follower has finished pre-scan and waits for its chain start
        ST_LEAD,    // follower lead-in between chain start and pixel 1
        ST_ACTIVE   // active pixels are being read out
    } scan_st_t;
endpackage

// File: rtl/scan_start_edge.sv
// Turns a level start input into a single-clock pulse on its rising edge.
// Assumes: the input is stable around the falling clock edge that samples it.
module scan_start_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic go_o
);
    logic prev_q;

    // Remember the level seen at the previous falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign go_o = lvl_i & ~prev_q;

    // A held-high start must never give two loads in a row.
    p_no_double_load_r7: assert property (@(negedge clk) disable iff (!rst_n)
        go_o |=> !go_o);
endmodule

// File: rtl/scan_res_map.sv
// Maps a resolution code to the last active pixel number and the pixel that
// carries the hand-off pulse. Each step of the code halves the pixel count.
// Assumes: FULL_PIX is divisible by 2**(MODES-1) and larger than EARLY.
module scan_res_map #(
    parameter int FULL_PIX = 1376,
    parameter int EARLY    = 9,
    parameter int RES_W    = 2,
    parameter int NUM_W    = 11
) (
    input  logic [RES_W-1:0] res_i,
    output logic [NUM_W-1:0] last_o,
    output logic [NUM_W-1:0] hand_o
);
    localparam int MODES = 1 << RES_W;

    logic [NUM_W-1:0] last_tbl [MODES];

    // One entry per resolution mode, each half the one before.
    for (genvar g = 0; g < MODES; g++) begin : g_mode
        assign last_tbl[g] = NUM_W'(FULL_PIX >> g);
    end

    assign last_o = last_tbl[res_i];
    assign hand_o = last_o - NUM_W'(EARLY);

    // Hand-off pixel lies inside the active range for every mode.
    always_comb begin
        p_hand_in_range_r3: assert (hand_o >= NUM_W'(1) && hand_o < last_o);
    end
endmodule

// File: rtl/scan_ctrl.sv
// Scan phase machine of one die: pre-scan dummy clocks, follower wait and
// lead-in, then the active pixel readout with its hand-off pulse.
// Assumes: start pulses are single-clock (from scan_start_edge); the strap is
// static during a scan; last_i/hand_i come from the captured resolution.
module scan_ctrl
    import line_scan_pkg::*;
#(
    parameter int DUMMY_CLKS = 75,
    parameter int LEAD_CLKS  = 9,
    parameter int RES_W      = 2,
    parameter int NUM_W      = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_go_i,
    input  logic             chain_go_i,
    input  logic             lead_strap_i,
    input  logic [RES_W-1:0] res_i,
    input  logic [NUM_W-1:0] last_i,
    input  logic [NUM_W-1:0] hand_i,
    output logic [RES_W-1:0] res_q_o,
    output logic             valid_o,
    output logic [NUM_W-1:0] num_o,
    output logic             handoff_o
);
    localparam int CNT_MAX = (DUMMY_CLKS > LEAD_CLKS) ? DUMMY_CLKS : LEAD_CLKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    scan_st_t         state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [NUM_W-1:0] num_q;
    logic [RES_W-1:0] res_q;

    // Advance the scan phase, the dummy/lead counter and the pixel number.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            num_q   <= '0;
            res_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_WAIT: begin
                    if (glob_go_i) begin
                        state_q <= ST_PRE;
                        cnt_q   <= CNT_W'(1);
                        res_q   <= res_i;
                    end else if (chain_go_i && !lead_strap_i) begin
                        state_q <= ST_LEAD;
                        cnt_q   <= CNT_W'(1);
                        res_q   <= res_i;
                    end
                end
                ST_PRE: begin
                    if (cnt_q == CNT_W'(DUMMY_CLKS)) begin
                        cnt_q <= '0;
                        if (lead_strap_i) begin
                            state_q <= ST_ACTIVE;
                            num_q   <= NUM_W'(1);
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_LEAD: begin
                    if (cnt_q == CNT_W'(LEAD_CLKS)) begin
                        cnt_q   <= '0;
                        state_q <= ST_ACTIVE;
                        num_q   <= NUM_W'(1);
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_ACTIVE: begin
                    if (num_q == last_i) begin
                        state_q <= ST_IDLE;
                        num_q   <= '0;
                    end else begin
                        num_q <= num_q + NUM_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign res_q_o   = res_q;
    assign valid_o   = (state_q == ST_ACTIVE);
    assign num_o     = num_q;
    assign handoff_o = valid_o && (num_q == hand_i);

    // Hand-off pulse is exactly one clock wide.
    p_handoff_width_r4: assert property (@(negedge clk) disable iff (!rst_n)
        handoff_o |=> !handoff_o);

    // Pixel number steps by one while the readout has not reached its end.
    p_pixel_step_r2: assert property (@(negedge clk) disable iff (!rst_n)
        (valid_o && num_q != last_i) |=> (valid_o && num_q == $past(num_q) + NUM_W'(1)));

    // A waiting follower stays dark unless its chain start arrives.
    p_follower_waits_r5: assert property (@(negedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !glob_go_i && !chain_go_i) |=> !valid_o);

    // Starts cannot cut a readout short.
    p_busy_ignore_r8: assert property (@(negedge clk) disable iff (!rst_n)
        (valid_o && num_q != last_i) |=> valid_o);

    // Captured resolution does not move during a readout.
    p_res_hold_r11: assert property (@(negedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> $stable(res_q));
endmodule

// File: rtl/line_scan_seq.sv
// Top of the cascadable line-scan readout sequencer: edge detection of both
// start inputs, resolution mapping and the scan phase machine.
// Assumes: the strap is tied off; the chain start comes from the previous
// die's hand-off output; everything runs on the falling pixel-clock edge.
module line_scan_seq #(
    parameter int FULL_PIX   = 1376,
    parameter int DUMMY_CLKS = 75,
    parameter int EARLY      = 9,
    parameter int RES_W      = 2,
    parameter int NUM_W      = $clog2(FULL_PIX + 1)
) (
    input  logic             clk_pix,
    input  logic             rst_n,
    input  logic             glob_start_i,
    input  logic             chain_start_i,
    input  logic             lead_strap_i,
    input  logic [RES_W-1:0] res_sel_i,
    output logic             pix_valid_o,
    output logic [NUM_W-1:0] pix_num_o,
    output logic             handoff_o,
    output logic             amp_pwr_o
);
    // Lead-in equals the hand-off advance so the chained stream has no gap.
    localparam int LEAD_CLKS = EARLY;

    logic             glob_go, chain_go;
    logic [RES_W-1:0] res_q;
    logic [NUM_W-1:0] last_pix, hand_pix;

    scan_start_edge u_glob_edge (
        .clk(clk_pix), .rst_n(rst_n), .lvl_i(glob_start_i), .go_o(glob_go)
    );

    scan_start_edge u_chain_edge (
        .clk(clk_pix), .rst_n(rst_n), .lvl_i(chain_start_i), .go_o(chain_go)
    );

    scan_res_map #(
        .FULL_PIX(FULL_PIX), .EARLY(EARLY), .RES_W(RES_W), .NUM_W(NUM_W)
    ) u_res_map (
        .res_i(res_q), .last_o(last_pix), .hand_o(hand_pix)
    );

    scan_ctrl #(
        .DUMMY_CLKS(DUMMY_CLKS), .LEAD_CLKS(LEAD_CLKS), .RES_W(RES_W), .NUM_W(NUM_W)
    ) u_ctrl (
        .clk(clk_pix), .rst_n(rst_n),
        .glob_go_i(glob_go), .chain_go_i(chain_go), .lead_strap_i(lead_strap_i),
        .res_i(res_sel_i), .last_i(last_pix), .hand_i(hand_pix),
        .res_q_o(res_q), .valid_o(pix_valid_o), .num_o(pix_num_o),
        .handoff_o(handoff_o)
    );

    // Amplifier is powered exactly while this die drives pixels.
    assign amp_pwr_o = pix_valid_o;

    // Amplifier never powered while no pixel of this die is out.
    p_amp_follows_r9: assert property (@(negedge clk_pix) disable iff (!rst_n)
        (!pix_valid_o) |-> !amp_pwr_o);
endmodule

// File: tb/line_scan_seq_tb_top.sv
// Bench: vector table of resolution modes walked by one loop, then directed
// cases for reset, follower start, held and stray starts, and resolution capture.
module line_scan_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glob = 1'b0;
    logic        chain = 1'b0;
    logic        strap = 1'b0;
    logic [1:0]  res = 2'b00;
    logic        valid, hand, amp;
    logic [10:0] num;

    int tests = 0;
    int fails = 0;
    int c = 0;
    bit done = 1'b0;

    // Per mode: active pixel count and hand-off pixel.
    localparam int VEC_LAST [4] = '{1376, 688, 344, 172};
    localparam int VEC_HAND [4] = '{1367, 679, 335, 163};

    always #2.5 clk = ~clk;

    line_scan_seq dut_i (
        .clk_pix(clk), .rst_n(rst_n), .glob_start_i(glob), .chain_start_i(chain),
        .lead_strap_i(strap), .res_sel_i(res), .pix_valid_o(valid),
        .pix_num_o(num), .handoff_o(hand), .amp_pwr_o(amp)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at clock %0d: got %0d expected %0d", req, c, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        c++;
    endtask

    task automatic run_to(input int n);
        while (c < n) tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; glob = 1'b0; chain = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic pulse_glob();
        c = 0; glob = 1'b1; tick(); glob = 1'b0;
    endtask

    task automatic pulse_chain();
        c = 0; chain = 1'b1; tick(); chain = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 valid", int'(valid), 0);
        chk("R1 num", int'(num), 0);
        chk("R1 handoff", int'(hand), 0);
        chk("R1 amp", int'(amp), 0);

        // Vector walk over the four resolution codes on a lead die.
        for (int v = 0; v < 4; v++) begin
            do_reset();
            res = 2'(v);
            strap = 1'b1;
            pulse_glob();
            for (int k = 1; k <= 75 + VEC_LAST[v] + 3; k++) begin
                run_to(k);
                begin
                    int ev, en;
                    ev = (k >= 76 && k <= 75 + VEC_LAST[v]) ? 1 : 0;
                    en = ev ? k - 75 : 0;
                    chk("R2/R3 valid", int'(valid), ev);
                    chk("R2/R3 num", int'(num), en);
                    chk("R4 handoff", int'(hand), (k == 75 + VEC_HAND[v]) ? 1 : 0);
                    chk("R9 amp", int'(amp), ev);
                end
            end
        end

        // R4: full-resolution landmarks on absolute clocks.
        do_reset(); res = 2'b00; strap = 1'b1; pulse_glob();
        run_to(1441); chk("R4 no handoff 1441", int'(hand), 0);
        run_to(1442); chk("R4 handoff 1442", int'(hand), 1);
        run_to(1443); chk("R4 handoff width", int'(hand), 0);
        run_to(1451); chk("R4 last pixel 1451", int'(num), 1376);
        run_to(1452); chk("R4 done 1452", int'(valid), 0);

        // R5/R6: follower.
        do_reset(); res = 2'b10; strap = 1'b0; pulse_glob();
        run_to(76);  chk("R5 no self start 76", int'(valid), 0);
        run_to(200); chk("R5 no self start 200", int'(valid), 0);
        chk("R5 amp off", int'(amp), 0);
        pulse_chain();
        run_to(9);   chk("R6 dark clock 9", int'(valid), 0);
        run_to(10);  chk("R6 pixel1 clock 10", int'(num), 1);
        chk("R6 valid clock 10", int'(valid), 1);
        run_to(344); chk("R6 handoff pixel 335", int'(hand), 1);
        run_to(353); chk("R6 last pixel 344", int'(num), 344);
        run_to(354); chk("R6 done", int'(valid), 0);

        // R7: held-high global start loads once.
        do_reset(); res = 2'b11; strap = 1'b1;
        c = 0; glob = 1'b1; tick();
        run_to(76);  chk("R7 first scan", int'(num), 1);
        run_to(248); chk("R7 ended", int'(valid), 0);
        run_to(400); chk("R7 no reload", int'(valid), 0);
        glob = 1'b0;

        // R8: stray starts during a scan.
        do_reset(); res = 2'b11; strap = 1'b1; pulse_glob();
        run_to(40); glob = 1'b1; tick(); glob = 1'b0;
        run_to(100); glob = 1'b1; chain = 1'b1; tick(); glob = 1'b0; chain = 1'b0;
        run_to(150); chk("R8 num unchanged", int'(num), 75);
        run_to(238); chk("R8 handoff kept", int'(hand), 1);
        run_to(248); chk("R8 ends on time", int'(valid), 0);

        // R10: lead die ignores chain start.
        do_reset(); res = 2'b11; strap = 1'b1; pulse_chain();
        run_to(100); chk("R10 valid", int'(valid), 0);
        chk("R10 amp", int'(amp), 0);

        // R11: resolution captured at start.
        do_reset(); res = 2'b11; strap = 1'b1; pulse_glob();
        res = 2'b00;
        run_to(238); chk("R11 handoff pixel 163", int'(hand), 1);
        run_to(247); chk("R11 last 172", int'(num), 172);
        run_to(248); chk("R11 stops", int'(valid), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule